// File: doc/BRIEF.md
# Four-Role Built-In Logic Block Observer Register

This block is a 4-bit test register. A 2-bit role input selects what it does at run time. In normal operation it is a plain D register that captures a parallel word. For test access it becomes a serial shift chain. During self-test it becomes an autonomous pseudorandom pattern source, or a multiple-input signature register that folds a parallel response into a running signature.

The pattern and signature roles share one feedback polynomial, x^4 + x^3 + 1. A typical session follows these steps:
1. Shift or load a seed.
2. Let the register generate patterns for a circuit under test.
3. Have a second instance compact that circuit's responses.
4. Shift the signature out through the serial output.

The serial output is always the most significant stage, so no extra multiplexing is needed to unload it.

Reset is asynchronous and active low. It clears the register at once, and its release is synchronised to the clock inside the block.

Top module: `bilbo_reg`

## Requirements
- R1: While rst_n is low, par_out is 0000. After rst_n rises, the register stays 0000 for two more rising edges, while the release is synchronised.
- R2: With role 2'b00 (shift), each rising edge moves bit i into bit i+1, and scan_in enters bit 0. par_in has no effect.
- R3: scan_out equals par_out[3] in every role and at every time.
- R4: With role 2'b01 (pattern) and a nonzero state, the next state is {q[2:0], q[3]^q[2]}. par_in and scan_in have no effect.
- R5: Started from 0001 in role 2'b01, the register passes through all 15 nonzero states and returns to 0001 on the 15th edge, with no earlier repeat.
- R6: With role 2'b01 and state 0000, the next edge loads the seed 0001.
- R7: With role 2'b10 (capture), each rising edge loads par_in into the register.
- R8: With role 2'b11 (compact), the next state is {q[2:0], q[3]^q[2]} XOR par_in. State 0000 is allowed there, and with par_in = 0000 it holds at 0000.
- R9: A change of the role input acts on the very next rising edge, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode | input | 2 | Role select: 00 shift, 01 pattern, 10 capture, 11 compact |
| par_in | input | 4 | Parallel data / response input |
| scan_in | input | 1 | Serial shift input into bit 0 |
| par_out | output | 4 | Register contents |
| scan_out | output | 1 | Serial output, the most significant stage |

## Verification
Every role updates the register on the first rising edge after the inputs are set up, through one register stage. The bench therefore drives the inputs on the falling edge and compares par_out and scan_out against its reference model 1 ns after the next rising edge. Reset release is the only multi-cycle result. It is checked by holding the register at 0000 for the two synchroniser edges before comparison against the model starts.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;

  typedef enum logic [1:0] {
    ROLE_SHIFT   = 2'b00,
    ROLE_PATTERN = 2'b01,
    ROLE_CAPTURE = 2'b10,
    ROLE_COMPACT = 2'b11
  } role_e;

endpackage

// File: rtl/bilbo_rst_sync.sv
module bilbo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/bilbo_feedback.sv
module bilbo_feedback #(
  parameter int            WIDTH = 4,
  parameter logic [WIDTH-1:0] TAPS = 4'b1100
) (
  input  logic [WIDTH-1:0] state,
  output logic             fb
);

  logic [WIDTH-1:0] tapped;

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_tap
      if (TAPS[g]) begin : g_on
        assign tapped[g] = state[g];
      end else begin : g_off
        assign tapped[g] = 1'b0;
      end
    end
  endgenerate

  assign fb = ^tapped;

endmodule

// File: rtl/bilbo_next.sv
module bilbo_next
  import bilbo_pkg::*;
#(
  parameter int               WIDTH = 4,
  parameter logic [WIDTH-1:0] TAPS  = 4'b1100,
  parameter logic [WIDTH-1:0] SEED  = 4'b0001
) (
  input  role_e            role,
  input  logic [WIDTH-1:0] state,
  input  logic [WIDTH-1:0] par_in,
  input  logic             scan_in,
  output logic [WIDTH-1:0] state_nxt
);

  logic             fb;
  logic [WIDTH-1:0] shifted;
  logic             is_zero;

  bilbo_feedback #(.WIDTH(WIDTH), .TAPS(TAPS)) u_fb (
    .state (state),
    .fb    (fb)
  );

  assign shifted = {state[WIDTH-2:0], fb};
  assign is_zero = (state == '0);

  always_comb begin
    unique case (role)
      ROLE_SHIFT:   state_nxt = {state[WIDTH-2:0], scan_in};
      ROLE_PATTERN: state_nxt = is_zero ? SEED : shifted;
      ROLE_CAPTURE: state_nxt = par_in;
      ROLE_COMPACT: state_nxt = shifted ^ par_in;
      default:      state_nxt = state;
    endcase
  end

endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
  import bilbo_pkg::*;
#(
  parameter int               WIDTH = 4,
  parameter logic [WIDTH-1:0] TAPS  = 4'b1100,
  parameter logic [WIDTH-1:0] SEED  = 4'b0001,
  parameter int               SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] par_in,
  input  logic             scan_in,
  output logic [WIDTH-1:0] par_out,
  output logic             scan_out
);

  localparam int MSB = WIDTH - 1;

  logic             srst_n;
  role_e            role;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;
  logic             state_en;

  bilbo_rst_sync #(.STAGES(SYNC)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  assign role = role_e'(mode);

  bilbo_next #(.WIDTH(WIDTH), .TAPS(TAPS), .SEED(SEED)) u_next (
    .role      (role),
    .state     (state_q),
    .par_in    (par_in),
    .scan_in   (scan_in),
    .state_nxt (state_d)
  );

  assign state_en = 1'b1;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)       state_q <= '0;
    else if (state_en) state_q <= state_d;
  end

  assign par_out  = state_q;
  assign scan_out = state_q[MSB];

  // R2
  shift_move_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (mode == 2'b00) |=> (state_q == {$past(state_q[MSB-1:0]), $past(scan_in)}));

  // R4
  pattern_live_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (mode == 2'b01 && state_q != '0) |=> (state_q != '0));

  // R6
  pattern_seed_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (mode == 2'b01 && state_q == '0) |=> (state_q == SEED));

  // R7
  capture_load_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (mode == 2'b10) |=> (state_q == $past(par_in)));

  // R8
  compact_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (mode == 2'b11 && state_q == '0 && par_in == '0) |=> (state_q == '0));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    (!srst_n) |-> (par_out == '0));

endmodule

// File: tb/sim_bilbo_reg.sv
module sim_bilbo_reg;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic [3:0] par_in;
  logic       scan_in;
  logic [3:0] par_out;
  logic       scan_out;

  int total = 0;
  int bad   = 0;
  logic [3:0] model;
  bit done = 0;

  always #2 clk = ~clk;

  bilbo_reg u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .par_in(par_in),
    .scan_in(scan_in), .par_out(par_out), .scan_out(scan_out)
  );

  function automatic logic [3:0] ref_next(input logic [1:0] m, input logic [3:0] q,
                                          input logic [3:0] d, input logic s);
    logic [3:0] sh;
    sh = {q[2:0], q[3] ^ q[2]};
    case (m)
      2'b00:   return {q[2:0], s};
      2'b01:   return (q == 4'b0000) ? 4'b0001 : sh;
      2'b10:   return d;
      default: return sh ^ d;
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic [3:0] d, input logic s, input string req);
    @(negedge clk);
    mode = m; par_in = d; scan_in = s;
    @(posedge clk);
    model = ref_next(m, model, d, s);
    #1;
    check(req, par_out, model);
    check("R3", {3'b000, scan_out}, {3'b000, par_out[3]});
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] seen;
    int unsigned rs;
    rst_n = 1'b0; mode = 2'b10; par_in = 4'hF; scan_in = 1'b1;
    rs = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    #1 check("R1", par_out, 4'b0000);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 check("R1", par_out, 4'b0000);
    @(posedge clk); #1 check("R1", par_out, 4'b0000);
    @(negedge clk) par_in = 4'h0;
    @(posedge clk);
    model = 4'b0000;

    // R6: zero state in pattern role loads the seed
    step(2'b01, 4'hA, 1'b1, "R6");
    check("R6", par_out, 4'b0001);
    // R5: full period of 15
    seen = par_out;
    for (int i = 1; i <= 15; i++) begin
      step(2'b01, 4'(i), 1'b0, "R4");
      if (i < 15 && par_out == seen) check("R5", par_out, ~seen);
    end
    check("R5", par_out, 4'b0001);

    // R8: compact holds zero with zero input
    step(2'b10, 4'h0, 1'b0, "R7");
    step(2'b11, 4'h0, 1'b0, "R8");
    check("R8", par_out, 4'b0000);
    step(2'b11, 4'h6, 1'b0, "R8");
    step(2'b11, 4'h9, 1'b0, "R8");
    step(2'b11, 4'h0, 1'b0, "R8");

    // R2/R3: shift signature out, MSB first, then one-mode-per-edge changes (R9)
    for (int i = 0; i < 4; i++) step(2'b00, 4'hF, 1'b0, "R2");
    step(2'b10, 4'hC, 1'b1, "R9");
    step(2'b00, 4'h3, 1'b1, "R9");
    step(2'b11, 4'h5, 1'b0, "R9");
    step(2'b01, 4'h5, 1'b0, "R9");

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      step(m, 4'($urandom), 1'($urandom), m == 2'b00 ? "R2" : m == 2'b01 ? "R4" :
           m == 2'b10 ? "R7" : "R8");
    end

    // R1: asynchronous clear mid-run
    @(negedge clk) mode = 2'b10; par_in = 4'hF;
    @(posedge clk); #1;
    rst_n = 1'b0;
    #0.5 check("R1", par_out, 4'b0000);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 check("R1", par_out, 4'b0000);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule